// File: doc/BRIEF.md
# Staged Interrupt Status Controller

This block gathers interrupt events for a camera-receiver style peripheral and presents them to software through a small register port. It holds one top-level group, one receiver group and a parameterised number of per-channel groups. Each group has four registers: a sticky status, an enable mask, a staged clear and a staged set. Each status bit is set by a one-cycle event pulse. A single interrupt output is high whenever any enabled status bit is set.

Writes to the clear and set registers do not change status when they are written. They only load a staging register. A write to the global command register then applies every group's staged clears, every group's staged sets, or both, at the same clock edge. Software services an interrupt by reading each status, writing that value back to the matching clear register, and then issuing one clear command.

A write of a nonzero value to the reset-strobe register starts an internal reset of fixed length. While it runs, event inputs are blocked. When it ends, the top group's bit 0 records a reset-done event. Masks and staged values are kept through it.

Top module: `isc_top`

## Requirements
- R1: After reset deassertion every status, mask, staged-clear and staged-set register reads 0 and `irq_o` is low.
- R2: Addresses are byte addresses with bits [1:0] zero. Group select is `addr[ADDR_W-1:4]` and the word within the group is `addr[3:2]`. Group 0 holds the reset strobe at 0x04 and the command register at 0x08. The top group is at 0x10, the receiver group at 0x20, and channel n at 0x30 + 0x10*n. Inside a group, status is at +0x0, mask at +0x4, staged clear at +0x8 and staged set at +0xC. Any other address reads 0.
- R3: Mask, staged-clear and staged-set registers read back the low STAT_W bits of the last value written to them.
- R4: An event pulse on an input bit sets the matching status bit, which then stays set. Writes to a status address have no effect.
- R5: A write to a staged-clear register leaves status unchanged. A command write with bit 0 set clears, at that one edge and in every group, the status bits named by each staged-clear register, and zeroes every staged-clear register.
- R6: A write to a staged-set register leaves status unchanged. A command write with bit 4 set ORs every staged-set register into its status at one edge, and zeroes every staged-set register.
- R7: When one command write has both bit 0 and bit 4 set, the clear is applied first and then the set, so a bit that is both staged-clear and staged-set ends up set.
- R8: An event on a bit in the same cycle as a committed clear of that bit leaves the bit set.
- R9: `irq_o` is the OR over all groups of status AND mask, registered: it changes one cycle after the status or mask change that causes it.
- R10: A nonzero write to the reset strobe sets top status bit 0 exactly RST_CYCLES clock edges after the write edge. A zero write has no effect. Masks and staged registers keep their values.
- R11: While the internal reset runs, event inputs are ignored and further strobe writes do not restart it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| top_evt_i | input | STAT_W-1 | Event pulses for top status bits [STAT_W-1:1] |
| rx_evt_i | input | STAT_W | Event pulses for receiver status |
| chan_evt_i | input | NUM_CHAN*STAT_W | Event pulses for channel n in bits [n*STAT_W +: STAT_W] |
| irq_o | output | 1 | Combined registered interrupt |

## Verification
The bench drives single-bit events through every bit of every group. This separates a fault in one lane, or in one group's address decode, from a fault that affects all groups. The mask is swept with one bit enabled, both matching and not matching the event bit, which tells the enable path apart from the sticky path. The cycle in which `irq_o` changes is checked on both rising and falling edges. Multi-group patterns with a single command separate a global commit from a per-group commit. Dedicated cases cover clear and set in one command, an event colliding with a clear, the exact reset-done cycle, and the blocking of events and repeated strobes during the internal reset.

// File: rtl/isc_pkg.sv
package isc_pkg;
    localparam int BUS_W       = 32;
    // word index inside a register group (addr[3:2])
    localparam int W_STATUS    = 0;
    localparam int W_MASK      = 1;
    localparam int W_CLEAR     = 2;
    localparam int W_SET       = 3;
    // word index inside the control group 0
    localparam int W_STROBE    = 1;
    localparam int W_CMD       = 2;
    // command register bit positions
    localparam int CMD_CLR_BIT = 0;
    localparam int CMD_SET_BIT = 4;

    typedef struct packed {
        logic wr_mask;
        logic wr_clr;
        logic wr_set;
    } grp_wr_t;
endpackage

// File: rtl/isc_group.sv
module isc_group
    import isc_pkg::*;
#(
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  grp_wr_t           wr,
    input  logic [STAT_W-1:0] wdata,
    input  logic              cmd_clr,
    input  logic              cmd_set,
    input  logic [STAT_W-1:0] evt,
    output logic [STAT_W-1:0] status_o,
    output logic [STAT_W-1:0] mask_o,
    output logic [STAT_W-1:0] clr_o,
    output logic [STAT_W-1:0] set_o
);
    typedef struct packed {
        logic [STAT_W-1:0] status;
        logic [STAT_W-1:0] mask;
        logic [STAT_W-1:0] sclr;
        logic [STAT_W-1:0] sset;
    } grp_st_t;

    grp_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // clear first, then set, then hardware events on top
        st_d.status = (st_q.status & ~(cmd_clr ? st_q.sclr : '0))
                    | (cmd_set ? st_q.sset : '0)
                    | evt;
        if (cmd_clr)    st_d.sclr = '0;
        if (cmd_set)    st_d.sset = '0;
        if (wr.wr_mask) st_d.mask = wdata;
        if (wr.wr_clr)  st_d.sclr = wdata;
        if (wr.wr_set)  st_d.sset = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q.status;
    assign mask_o   = st_q.mask;
    assign clr_o    = st_q.sclr;
    assign set_o    = st_q.sset;

    p_evt_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((status_o & $past(evt)) == $past(evt)));

    p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_set && evt == '0) |=> ((status_o & ~$past(status_o)) == '0));

    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_clr |=> (($past(status_o) & ~status_o) == '0));

    p_clr_drained_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_clr && !wr.wr_clr) |=> (clr_o == '0));

    p_set_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_set |=> ((status_o & $past(set_o)) == $past(set_o)));

    p_evt_beats_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_clr && (evt & clr_o) != '0)
        |=> ((status_o & $past(evt & clr_o)) == $past(evt & clr_o)));
endmodule

// File: rtl/isc_rst_seq.sv
module isc_rst_seq #(
    parameter int RST_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy_o,
    output logic done_o
);
    localparam int CNT_W = $clog2(RST_CYCLES + 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        done_o = st_q.busy && (st_q.cnt == '0);
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy = 1'b1;
                st_d.cnt  = CNT_W'(RST_CYCLES - 1);
            end
        end else if (st_q.cnt == '0) begin
            st_d.busy = 1'b0;
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = st_q.busy;

    p_done_ends_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

    p_count_down_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && st_q.cnt != '0) |=> (busy_o && st_q.cnt == $past(st_q.cnt) - 1'b1));

    p_no_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start && st_q.cnt != '0) |=> (st_q.cnt != CNT_W'(RST_CYCLES - 1)));
endmodule

// File: rtl/isc_top.sv
module isc_top
    import isc_pkg::*;
#(
    parameter int NUM_CHAN   = 2,
    parameter int STAT_W     = 8,
    parameter int ADDR_W     = 8,
    parameter int RST_CYCLES = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [31:0]                  wdata,
    output logic [31:0]                  rdata,
    input  logic [STAT_W-2:0]            top_evt_i,
    input  logic [STAT_W-1:0]            rx_evt_i,
    input  logic [NUM_CHAN*STAT_W-1:0]   chan_evt_i,
    output logic                         irq_o
);
    localparam int NG     = NUM_CHAN + 2;
    localparam int GSEL_W = ADDR_W - 4;

    logic [GSEL_W-1:0] gsel;
    logic [1:0]        word;
    logic              aligned;
    logic              cmd_clr, cmd_set, strobe;
    logic              busy, done;

    grp_wr_t           wr_v   [NG];
    logic [STAT_W-1:0] evt_v  [NG];
    logic [STAT_W-1:0] stat_v [NG];
    logic [STAT_W-1:0] mask_v [NG];
    logic [STAT_W-1:0] clr_v  [NG];
    logic [STAT_W-1:0] set_v  [NG];

    logic irq_d, irq_q;

    assign gsel    = addr[ADDR_W-1:4];
    assign word    = addr[3:2];
    assign aligned = (addr[1:0] == 2'b00);

    // control group decode
    always_comb begin
        cmd_clr = 1'b0;
        cmd_set = 1'b0;
        strobe  = 1'b0;
        if (wr_en && aligned && gsel == '0) begin
            if (word == 2'(W_CMD)) begin
                cmd_clr = wdata[CMD_CLR_BIT];
                cmd_set = wdata[CMD_SET_BIT];
            end
            if (word == 2'(W_STROBE)) strobe = (wdata != '0);
        end
    end

    // per-group write decode
    always_comb begin
        for (int k = 0; k < NG; k++) begin
            wr_v[k] = '0;
            if (wr_en && aligned && gsel == GSEL_W'(k + 1)) begin
                wr_v[k].wr_mask = (word == 2'(W_MASK));
                wr_v[k].wr_clr  = (word == 2'(W_CLEAR));
                wr_v[k].wr_set  = (word == 2'(W_SET));
            end
        end
    end

    // event routing; external events are blocked while the internal reset runs
    always_comb begin
        evt_v[0] = {top_evt_i & {(STAT_W-1){~busy}}, done};
        evt_v[1] = rx_evt_i & {STAT_W{~busy}};
        for (int n = 0; n < NUM_CHAN; n++)
            evt_v[n + 2] = chan_evt_i[n*STAT_W +: STAT_W] & {STAT_W{~busy}};
    end

    isc_rst_seq #(.RST_CYCLES(RST_CYCLES)) u_rst_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (strobe),
        .busy_o (busy),
        .done_o (done)
    );

    for (genvar g = 0; g < NG; g++) begin : g_grp
        isc_group #(.STAT_W(STAT_W)) u_grp (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr       (wr_v[g]),
            .wdata    (wdata[STAT_W-1:0]),
            .cmd_clr  (cmd_clr),
            .cmd_set  (cmd_set),
            .evt      (evt_v[g]),
            .status_o (stat_v[g]),
            .mask_o   (mask_v[g]),
            .clr_o    (clr_v[g]),
            .set_o    (set_v[g])
        );
    end

    // read mux
    always_comb begin
        rdata = '0;
        for (int k = 0; k < NG; k++) begin
            if (aligned && gsel == GSEL_W'(k + 1)) begin
                case (word)
                    2'(W_STATUS): rdata = BUS_W'(stat_v[k]);
                    2'(W_MASK):   rdata = BUS_W'(mask_v[k]);
                    2'(W_CLEAR):  rdata = BUS_W'(clr_v[k]);
                    default:      rdata = BUS_W'(set_v[k]);
                endcase
            end
        end
    end

    // combined interrupt
    always_comb begin
        irq_d = 1'b0;
        for (int k = 0; k < NG; k++)
            irq_d = irq_d | (|(stat_v[k] & mask_v[k]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq_o = irq_q;

    p_busy_blocks_rx_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cmd_set) |=> ((stat_v[1] & ~$past(stat_v[1])) == '0));

    p_strobe_keeps_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !wr_v[1].wr_mask) |=> (mask_v[1] == $past(mask_v[1])));
endmodule

// File: tb/isc_top_test.sv
`timescale 1ns/100ps
module isc_top_test;
    localparam int NC = 2;
    localparam int SW = 8;
    localparam int NG = NC + 2;
    localparam int RC = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [7:0]        addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic [SW-2:0]     top_evt_i = '0;
    logic [SW-1:0]     rx_evt_i = '0;
    logic [NC*SW-1:0]  chan_evt_i = '0;
    logic              irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    isc_top #(.NUM_CHAN(NC), .STAT_W(SW), .ADDR_W(8), .RST_CYCLES(RC)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .top_evt_i(top_evt_i), .rx_evt_i(rx_evt_i),
        .chan_evt_i(chan_evt_i), .irq_o(irq_o)
    );

    function automatic logic [7:0] base(input int g);
        return 8'((g + 1) * 16);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic set_evt(input int g, input logic [SW-1:0] b);
        if (g == 0)      top_evt_i = b[SW-1:1];
        else if (g == 1) rx_evt_i = b;
        else             chan_evt_i[(g-2)*SW +: SW] = b;
    endtask

    task automatic pulse(input int g, input logic [SW-1:0] b);
        @(negedge clk);
        set_evt(g, b);
        @(negedge clk);
        top_evt_i = '0; rx_evt_i = '0; chan_evt_i = '0;
    endtask

    task automatic clear_all();
        for (int g = 0; g < NG; g++) wr(base(g) + 8'h8, 32'hFF);
        wr(8'h08, 32'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int g = 0; g < NG; g++)
            for (int w = 0; w < 4; w++) begin
                rd(base(g) + 8'(w*4), v);
                chk("R1 reset register", v, 0);
            end
        chk("R1 irq after reset", {31'b0, irq_o}, 0);

        // R2 / R3 map and readback
        for (int g = 0; g < NG; g++) begin
            wr(base(g) + 8'h4, 32'hFFFF_FF00 | 32'(8'hA5 ^ 8'(g)));
            wr(base(g) + 8'h8, 32'(8'h3C ^ 8'(g)));
            wr(base(g) + 8'hC, 32'(8'h0F + 8'(g)));
        end
        for (int g = 0; g < NG; g++) begin
            rd(base(g) + 8'h4, v); chk("R3 mask readback", v, 32'(8'hA5 ^ 8'(g)));
            rd(base(g) + 8'h8, v); chk("R3 clear stage readback", v, 32'(8'h3C ^ 8'(g)));
            rd(base(g) + 8'hC, v); chk("R3 set stage readback", v, 32'(8'h0F + 8'(g)));
            rd(base(g), v);        chk("R5 R6 staging leaves status", v, 0);
        end
        rd(8'h00, v); chk("R2 unmapped 0x00", v, 0);
        rd(8'h04, v); chk("R2 strobe reads 0", v, 0);
        rd(8'h50, v); chk("R2 beyond last channel", v, 0);
        rd(8'h25, v); chk("R2 unaligned address", v, 0);
        for (int g = 0; g < NG; g++) begin
            wr(base(g) + 8'h4, 0); wr(base(g) + 8'h8, 0); wr(base(g) + 8'hC, 0);
        end

        // R4 / R5 per-bit sweep over every group
        for (int g = 0; g < NG; g++) begin
            for (int b = (g == 0) ? 1 : 0; b < SW; b++) begin
                pulse(g, 8'(1 << b));
                rd(base(g), v); chk("R4 event sets bit", v, 32'(1 << b));
                wr(base(g) + 8'h8, 32'(1 << b));
                rd(base(g), v); chk("R5 staged clear not yet applied", v, 32'(1 << b));
                wr(8'h08, 32'h1);
                rd(base(g), v); chk("R5 committed clear", v, 0);
                rd(base(g) + 8'h8, v); chk("R5 staged clear drained", v, 0);
            end
            pulse(g, 8'h02);
            repeat (3) @(negedge clk);
            rd(base(g), v); chk("R4 sticky", v, 32'h02);
            wr(base(g), 32'hFF);
            rd(base(g), v); chk("R4 status write ignored", v, 32'h02);
            clear_all();
        end

        // R5 one command clears all groups
        for (int g = 0; g < NG; g++) pulse(g, 8'hF0 | 8'(g * 2));
        for (int g = 0; g < NG; g++) wr(base(g) + 8'h8, 32'(8'h30 | 8'(g * 2)));
        wr(8'h08, 32'h1);
        for (int g = 0; g < NG; g++) begin
            rd(base(g), v); chk("R5 global clear", v, 32'h0C0);
        end
        clear_all();

        // R6 staged set
        for (int g = 0; g < NG; g++) wr(base(g) + 8'hC, 32'(8'h11 << (g % 4)));
        for (int g = 0; g < NG; g++) begin
            rd(base(g), v); chk("R6 staged set not yet applied", v, 0);
        end
        wr(8'h08, 32'h10);
        for (int g = 0; g < NG; g++) begin
            rd(base(g), v);        chk("R6 committed set", v, 32'(8'h11 << (g % 4)));
            rd(base(g) + 8'hC, v); chk("R6 staged set drained", v, 0);
        end
        clear_all();

        // R7 clear and set in one command
        pulse(1, 8'h3C);
        wr(8'h28, 32'hFF);
        wr(8'h2C, 32'h81);
        wr(8'h08, 32'h11);
        rd(8'h20, v); chk("R7 clear then set", v, 32'h81);
        clear_all();

        // R8 event collides with committed clear
        pulse(1, 8'h06);
        wr(8'h28, 32'h06);
        @(negedge clk);
        wr_en = 1'b1; addr = 8'h08; wdata = 32'h1; rx_evt_i = 8'h04;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0; rx_evt_i = '0;
        rd(8'h20, v); chk("R8 event wins over clear", v, 32'h04);
        clear_all();

        // R9 irq timing and masking sweep
        for (int g = 0; g < NG; g++) begin
            for (int b = (g == 0) ? 1 : 0; b < SW; b++) begin
                wr(base(g) + 8'h4, 32'(~(8'(1 << b))));
                pulse(g, 8'(1 << b));
                @(negedge clk);
                chk("R9 masked-off event no irq", {31'b0, irq_o}, 0);
                wr(base(g) + 8'h4, 32'(1 << b));
                chk("R9 irq one cycle after mask", {31'b0, irq_o}, 0);
                @(negedge clk);
                chk("R9 irq asserted", {31'b0, irq_o}, 1);
                wr(base(g) + 8'h8, 32'(1 << b));
                wr(8'h08, 32'h1);
                chk("R9 irq held one cycle after clear", {31'b0, irq_o}, 1);
                @(negedge clk);
                chk("R9 irq dropped", {31'b0, irq_o}, 0);
                wr(base(g) + 8'h4, 0);
            end
        end

        // R10 / R11 internal reset
        wr(8'h24, 32'h33);
        wr(8'h2C, 32'h44);
        wr(8'h04, 32'h0);
        repeat (RC + 4) @(negedge clk);
        rd(8'h10, v); chk("R10 zero strobe no effect", v, 0);
        wr(8'h04, 32'h1E);
        pulse(1, 8'hFF);
        pulse(2, 8'h0F);
        wr(8'h04, 32'h1);
        repeat (RC - 7) @(negedge clk);
        rd(8'h10, v); chk("R10 R11 done not before count", v, 0);
        @(negedge clk);
        rd(8'h10, v); chk("R10 done after exact count", v, 32'h1);
        rd(8'h20, v); chk("R11 rx events ignored while busy", v, 0);
        rd(8'h30, v); chk("R11 channel events ignored while busy", v, 0);
        rd(8'h24, v); chk("R10 mask preserved", v, 32'h33);
        rd(8'h2C, v); chk("R10 staged set preserved", v, 32'h44);
        pulse(1, 8'h08);
        rd(8'h20, v); chk("R11 events accepted after reset", v, 32'h08);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule